// File: doc/BRIEF.md
# Carrier Address Window Decoder

This block sits between a host bus slave and four mezzanine I/O module slots on a carrier card. It turns each host access into a slot index, a space type and a slot-local offset. Short-space (16-bit address) accesses fall into one relocatable 1 KB window. That window holds the I/O and ID spaces of all four slots. Standard-space (24-bit address) accesses are matched against four per-slot memory windows. Each memory window has its own base, its own size and its own enable bit. A small register write port sets up the windows. The bus handshake and the data path are handled elsewhere.

The core is a two-state machine. `ST_IDLE` waits for an access. The transition `IDLE_TO_SHOW` is taken on a cycle with `acc_valid` high. `ST_SHOW` presents a registered decode result for exactly one cycle per accepted access. From `ST_SHOW`, the transition `SHOW_TO_SHOW` is taken when a further access arrives back to back. The transition `SHOW_TO_IDLE` is taken when no access arrives. Each access is decoded against the window settings in force before any register write made in the same cycle.

Top module: `carrier_win_dec`

## Requirements
- R1: After reset, `dec_valid` and `dec_hit` are 0. Short-space decoding is off, all memory enables are off, and every access misses until the block is configured.
- R2: `dec_valid` is 1 in the cycle after a cycle with `acc_valid` high, and 0 otherwise. `dec_hit` is never 1 while `dec_valid` is 0. On a miss, `dec_slot`, `dec_space` and `dec_offset` read 0.
- R3: A write to register address 0 loads `cfg_wdata[5:0]` as short-window base bits [15:10]. A short access hits only when its address bits [15:10] equal this base. Bits [23:16] of a short access are ignored.
- R4: A write to address 1 with `cfg_wdata[0]`=1 turns short decoding on. A write to address 2 with `cfg_wdata[0]`=1 turns it off. Either write with `cfg_wdata[0]`=0 has no effect.
- R5: Window offsets 0x000–0x1FF map to I/O space (`dec_space`=1). The slot is offset[8:7] and the local offset is offset[6:0].
- R6: Window offsets 0x200–0x27F map to ID space (`dec_space`=0). The slot is offset[6:5] and the local offset is offset[4:0]. ID space hits only for byte accesses (`acc_word`=0) on odd addresses.
- R7: Window offsets 0x280–0x3FF never hit.
- R8: A write to address 4+k sets the memory window of slot k. `cfg_wdata[3:0]` is the base, meaning address bits [23:20]. `cfg_wdata[5:4]` is the size code: 0=1 MB, 1=2 MB, 2=4 MB, 3=8 MB. Base bits below the size are ignored. A hit gives `dec_space`=2 and the local offset = address modulo the size.
- R9: A write to address 3 loads `cfg_wdata[3:0]` as the memory enable mask, with bit k for slot k. A disabled slot never hits.
- R10: When several enabled memory windows match, the lowest-numbered slot is the only candidate.
- R11: In I/O and memory space, a 16-bit access (`acc_word`=1) on an odd address misses. Byte accesses are allowed at any address.
- R12: An access and a register write in the same cycle decode with the settings in force before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_short | input | 1 | 1 = short (16-bit) space, 0 = standard (24-bit) space |
| acc_word | input | 1 | 1 = 16-bit transfer, 0 = byte transfer |
| acc_addr | input | 24 | Access address |
| dec_valid | output | 1 | Decode result present |
| dec_hit | output | 1 | Access matched a window |
| dec_slot | output | 2 | Target slot index |
| dec_space | output | 2 | 0 = ID, 1 = I/O, 2 = memory |
| dec_offset | output | 23 | Slot-local offset |

## Verification
A register write and an access can land in the same cycle. This collision is exercised in two ways. In one case, the short window is disabled in the very cycle an access targets it. In the other, the memory enable mask is changed while an access to the affected slot is presented. The reference model in the bench applies writes only after it has decoded the same cycle's access. So the result one cycle later must reflect the old settings, and it is compared on every clock against the design's outputs.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
    localparam int NSLOT  = 4;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int OFF_W  = 23;

    typedef enum logic [1:0] {
        SP_ID  = 2'd0,
        SP_IO  = 2'd1,
        SP_MEM = 2'd2
    } space_e;

    typedef struct packed {
        logic              hit;
        logic [SLOT_W-1:0] slot;
        space_e            space;
        logic [OFF_W-1:0]  offset;
    } dec_t;
endpackage

// File: rtl/cwd_cfg_regs.sv
module cwd_cfg_regs
    import cwd_pkg::*;
#(
    parameter int RA_W   = 3,
    parameter int DW     = 8,
    parameter int SBASE_W = 6,
    parameter int MBASE_W = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [RA_W-1:0]                  waddr,
    input  logic [DW-1:0]                    wdata,
    output logic [SBASE_W-1:0]               short_base,
    output logic                             short_en,
    output logic [NSLOT-1:0]                 mem_en,
    output logic [NSLOT-1:0][MBASE_W-1:0]    mem_base,
    output logic [NSLOT-1:0][1:0]            mem_size
);
    localparam logic [RA_W-1:0] RA_BASE = RA_W'(0);
    localparam logic [RA_W-1:0] RA_SET  = RA_W'(1);
    localparam logic [RA_W-1:0] RA_CLR  = RA_W'(2);
    localparam logic [RA_W-1:0] RA_MEN  = RA_W'(3);
    localparam int              RA_SLOT0 = 4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            short_base <= '0;
            short_en   <= 1'b0;
            mem_en     <= '0;
        end else if (we) begin
            if (waddr == RA_BASE) short_base <= wdata[SBASE_W-1:0];
            if (waddr == RA_SET && wdata[0]) short_en <= 1'b1;
            if (waddr == RA_CLR && wdata[0]) short_en <= 1'b0;
            if (waddr == RA_MEN) mem_en <= wdata[NSLOT-1:0];
        end
    end

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_base[k] <= '0;
                mem_size[k] <= '0;
            end else if (we && waddr == RA_W'(RA_SLOT0 + k)) begin
                mem_base[k] <= wdata[MBASE_W-1:0];
                mem_size[k] <= wdata[MBASE_W+1:MBASE_W];
            end
        end
    end
endmodule

// File: rtl/cwd_short_dec.sv
module cwd_short_dec
    import cwd_pkg::*;
#(
    parameter int WIN_W = 10,
    parameter int IO_W  = 7,
    parameter int ID_W  = 5
) (
    input  logic                 en,
    input  logic [15-WIN_W:0]    base,
    input  logic [15:0]          addr,
    input  logic                 word,
    output dec_t                 res
);
    localparam int IO_SPAN_W = IO_W + SLOT_W;
    localparam int ID_SPAN_W = ID_W + SLOT_W;
    localparam int ID_TAG    = 1 << (IO_SPAN_W - ID_SPAN_W);

    logic [WIN_W-1:0] off;
    assign off = addr[WIN_W-1:0];

    always_comb begin
        res = '0;
        if (en && addr[15:WIN_W] == base) begin
            if (off[WIN_W-1:IO_SPAN_W] == '0) begin
                if (!(word && addr[0])) begin
                    res.hit    = 1'b1;
                    res.slot   = off[IO_SPAN_W-1:IO_W];
                    res.space  = SP_IO;
                    res.offset = OFF_W'(off[IO_W-1:0]);
                end
            end else if (off[WIN_W-1:ID_SPAN_W] == (WIN_W-ID_SPAN_W)'(ID_TAG)) begin
                if (!word && addr[0]) begin
                    res.hit    = 1'b1;
                    res.slot   = off[ID_SPAN_W-1:ID_W];
                    res.space  = SP_ID;
                    res.offset = OFF_W'(off[ID_W-1:0]);
                end
            end
        end
    end
endmodule

// File: rtl/cwd_mem_dec.sv
module cwd_mem_dec
    import cwd_pkg::*;
#(
    parameter int AW      = 24,
    parameter int BLK_W   = 20,
    parameter int MBASE_W = 4
) (
    input  logic [NSLOT-1:0]              en,
    input  logic [NSLOT-1:0][MBASE_W-1:0] base,
    input  logic [NSLOT-1:0][1:0]         size,
    input  logic [AW-1:0]                 addr,
    input  logic                          word,
    output dec_t                          res
);
    logic [NSLOT-1:0]            match;
    logic [NSLOT-1:0][OFF_W-1:0] loc;

    for (genvar k = 0; k < NSLOT; k++) begin : g_win
        logic [MBASE_W-1:0] msk;
        assign msk      = {MBASE_W{1'b1}} << size[k];
        assign match[k] = en[k] && (((addr[AW-1:BLK_W] ^ base[k]) & msk) == '0);
        assign loc[k]   = OFF_W'({addr[AW-2:BLK_W] & ~msk[MBASE_W-2:0], addr[BLK_W-1:0]});
    end

    always_comb begin
        logic found;
        res   = '0;
        found = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            if (!found && match[k]) begin
                found = 1'b1;
                if (!(word && addr[0])) begin
                    res.hit    = 1'b1;
                    res.slot   = SLOT_W'(k);
                    res.space  = SP_MEM;
                    res.offset = loc[k];
                end
            end
        end
    end
endmodule

// File: rtl/carrier_win_dec.sv
module carrier_win_dec
    import cwd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    input  logic        acc_valid,
    input  logic        acc_short,
    input  logic        acc_word,
    input  logic [23:0] acc_addr,
    output logic        dec_valid,
    output logic        dec_hit,
    output logic [1:0]  dec_slot,
    output logic [1:0]  dec_space,
    output logic [22:0] dec_offset
);
    typedef enum logic {ST_IDLE, ST_SHOW} state_e;

    state_e state_q, state_d;

    logic [5:0]             short_base;
    logic                   short_en;
    logic [NSLOT-1:0]       mem_en;
    logic [NSLOT-1:0][3:0]  mem_base;
    logic [NSLOT-1:0][1:0]  mem_size;
    dec_t                   sres, mres, res_q;

    cwd_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr), .wdata(cfg_wdata),
        .short_base(short_base), .short_en(short_en),
        .mem_en(mem_en), .mem_base(mem_base), .mem_size(mem_size)
    );

    cwd_short_dec u_sdec (
        .en(short_en), .base(short_base), .addr(acc_addr[15:0]),
        .word(acc_word), .res(sres)
    );

    cwd_mem_dec u_mdec (
        .en(mem_en), .base(mem_base), .size(mem_size),
        .addr(acc_addr), .word(acc_word), .res(mres)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (acc_valid) state_d = ST_SHOW;            // IDLE_TO_SHOW
            ST_SHOW: state_d = acc_valid ? ST_SHOW : ST_IDLE;     // SHOW_TO_SHOW / SHOW_TO_IDLE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         res_q <= '0;
        else if (acc_valid) res_q <= acc_short ? sres : mres;
        else                res_q <= '0;
    end

    assign dec_valid  = (state_q == ST_SHOW);
    assign dec_hit    = res_q.hit;
    assign dec_slot   = res_q.slot;
    assign dec_space  = res_q.space;
    assign dec_offset = res_q.offset;
endmodule

// File: rtl/cwd_chk.sv
module cwd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        dec_valid,
    input logic        dec_hit,
    input logic [1:0]  dec_slot,
    input logic [1:0]  dec_space,
    input logic [22:0] dec_offset,
    input logic        short_en,
    input logic [3:0]  mem_en
);
    // R2
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> dec_valid);
    // R2
    valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !dec_valid);
    // R2
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_hit |-> dec_valid);
    // R4
    short_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_space != 2'd2) |-> $past(short_en));
    // R9
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_space == 2'd2) |-> ((($past(mem_en)) >> dec_slot) & 4'd1) == 4'd1);
    // R6
    id_byte_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_space == 2'd0) |-> (dec_offset[0] && dec_offset < 23'd32));
    // R5
    io_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_hit && dec_space == 2'd1) |-> dec_offset < 23'd128);
endmodule

bind carrier_win_dec cwd_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .dec_valid(dec_valid),
    .dec_hit(dec_hit), .dec_slot(dec_slot), .dec_space(dec_space),
    .dec_offset(dec_offset), .short_en(short_en), .mem_en(mem_en)
);

// File: tb/carrier_win_dec_test.sv
`timescale 1ns/100ps
module carrier_win_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic        acc_short = 1'b0;
    logic        acc_word = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        dec_valid, dec_hit;
    logic [1:0]  dec_slot, dec_space;
    logic [22:0] dec_offset;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    carrier_win_dec uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_short(acc_short), .acc_word(acc_word), .acc_addr(acc_addr),
        .dec_valid(dec_valid), .dec_hit(dec_hit), .dec_slot(dec_slot),
        .dec_space(dec_space), .dec_offset(dec_offset)
    );

    // behavioural reference model
    logic [5:0]  m_sbase;
    logic        m_sen;
    logic [3:0]  m_men;
    logic [3:0]  m_mbase [4];
    logic [1:0]  m_msize [4];
    logic        exp_valid;
    logic [27:0] exp_res;

    function automatic logic [27:0] ref_dec(bit sh, logic [23:0] a, bit w);
        int off, sz;
        if (sh) begin
            if (!m_sen || int'(a[15:0]) / 1024 != int'(m_sbase)) return '0;
            off = int'(a[15:0]) % 1024;
            if (off < 512) begin
                if (w && a[0]) return '0;
                return {1'b1, 2'(off / 128), 2'd1, 23'(off % 128)};
            end
            if (off < 640) begin
                if (w || !a[0]) return '0;
                return {1'b1, 2'((off - 512) / 32), 2'd0, 23'(off % 32)};
            end
            return '0;
        end
        for (int k = 0; k < 4; k++) begin
            if (m_men[k]) begin
                sz = 1 << (20 + int'(m_msize[k]));
                if (int'(a) / sz == (int'(m_mbase[k]) << 20) / sz) begin
                    if (w && a[0]) return '0;
                    return {1'b1, 2'(k), 2'd2, 23'(int'(a) % sz)};
                end
            end
        end
        return '0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sbase <= '0; m_sen <= 1'b0; m_men <= '0;
            for (int k = 0; k < 4; k++) begin m_mbase[k] <= '0; m_msize[k] <= '0; end
            exp_valid <= 1'b0; exp_res <= '0;
        end else begin
            exp_valid <= acc_valid;
            exp_res   <= acc_valid ? ref_dec(acc_short, acc_addr, acc_word) : '0;
            if (cfg_we) begin
                case (int'(cfg_addr))
                    0: m_sbase <= cfg_wdata[5:0];
                    1: if (cfg_wdata[0]) m_sen <= 1'b1;
                    2: if (cfg_wdata[0]) m_sen <= 1'b0;
                    3: m_men <= cfg_wdata[3:0];
                    default: begin
                        m_mbase[int'(cfg_addr) - 4] <= cfg_wdata[3:0];
                        m_msize[int'(cfg_addr) - 4] <= cfg_wdata[5:4];
                    end
                endcase
            end
        end
    end

    // compare every clock, away from the edge
    always @(posedge clk) begin
        #1;
        checks++;
        if ({dec_valid, dec_hit, dec_slot, dec_space, dec_offset} !== {exp_valid, exp_res}) begin
            fails++;
            $display("FAIL %s: actual v=%0b h=%0b s=%0d sp=%0d o=%h expected v=%0b h=%0b s=%0d sp=%0d o=%h",
                     cur_req, dec_valid, dec_hit, dec_slot, dec_space, dec_offset,
                     exp_valid, exp_res[27], exp_res[26:25], exp_res[24:23], exp_res[22:0]);
        end
    end

    task automatic acc(bit sh, logic [23:0] a, bit w);
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b1; acc_short = sh; acc_addr = a; acc_word = w;
    endtask

    task automatic wr(logic [2:0] ra, logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b0; cfg_we = 1'b1; cfg_addr = ra; cfg_wdata = d;
    endtask

    task automatic both(logic [2:0] ra, logic [7:0] d, bit sh, logic [23:0] a, bit w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ra; cfg_wdata = d;
        acc_valid = 1'b1; acc_short = sh; acc_addr = a; acc_word = w;
    endtask

    task automatic idle();
        @(negedge clk);
        cfg_we = 1'b0; acc_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: unconfigured, everything misses
        cur_req = "R1";
        acc(1, 24'h000000, 0); acc(1, 24'h000201, 0); acc(0, 24'h000000, 0); idle();
        // R3 / R4: base 5 -> 0x1400, enable writes with bit0 clear do nothing
        cur_req = "R4";
        wr(3'd0, 8'h05); wr(3'd1, 8'hFE); acc(1, 24'h001400, 0);
        wr(3'd1, 8'h01); wr(3'd2, 8'h00); acc(1, 24'h001400, 0); idle();
        // R5: I/O layout, back to back (R2)
        cur_req = "R5";
        acc(1, 24'h001400, 1); acc(1, 24'h001481, 0); acc(1, 24'h0015FE, 1); acc(1, 24'hFF1537, 0); idle();
        // R11: word on odd address
        cur_req = "R11";
        acc(1, 24'h001403, 1); acc(1, 24'h001403, 0); idle();
        // R6: ID layout
        cur_req = "R6";
        acc(1, 24'h001601, 0); acc(1, 24'h001600, 0); acc(1, 24'h001621, 1); acc(1, 24'h00167F, 0); idle();
        // R7: upper part of the window
        cur_req = "R7";
        acc(1, 24'h001680, 0); acc(1, 24'h0017FF, 0); acc(1, 24'h001701, 0); idle();
        // R3: outside and relocated
        cur_req = "R3";
        acc(1, 24'h001000, 0); acc(1, 24'h001800, 0); wr(3'd0, 8'h3F);
        acc(1, 24'h001400, 0); acc(1, 24'h00FC82, 1); idle();
        // R12: disable in the same cycle as an access
        cur_req = "R12";
        both(3'd2, 8'h01, 1, 24'h00FC10, 0); acc(1, 24'h00FC10, 0); idle();
        // R8: memory windows, all disabled first (R9)
        cur_req = "R9";
        wr(3'd4, 8'h01); wr(3'd5, 8'h24); wr(3'd6, 8'h3B); wr(3'd7, 8'h05);
        acc(0, 24'h112345, 0); acc(0, 24'h812345, 1); idle();
        wr(3'd3, 8'h0D); acc(0, 24'h512346, 1); acc(0, 24'h112345, 0); idle();
        cur_req = "R8";
        wr(3'd3, 8'h0F);
        acc(0, 24'h1FFFFE, 1); acc(0, 24'h2FFFFE, 1); acc(0, 24'h7ABCDE, 0);
        acc(0, 24'hFEDCBA, 1); acc(0, 24'h812345, 0); acc(0, 24'h0ABCDE, 0); idle();
        // R10: slot1 (4 MB) and slot3 overlap at 0x5xxxxx
        cur_req = "R10";
        acc(0, 24'h5A0000, 1); acc(0, 24'h5A0001, 1); idle();
        cur_req = "R12";
        both(3'd3, 8'h0D, 0, 24'h5A0000, 1); acc(0, 24'h5A0000, 1); idle();
        cur_req = "R9";
        wr(3'd3, 8'h00); acc(0, 24'h5A0000, 1); idle(); idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule